// File: doc/BRIEF.md
# Programmable Traffic Light Sequencer

The block drives the three lamps of one traffic signal. It steps through red, green and yellow phases. Each phase lasts a number of clocks taken from a packed timer word. Two timer words are held: one for peak hours and one for off-peak. A profile bit in the control word picks which of the two is used.

Two override modes make a single lamp flash: red or yellow, alternating with a dark interval. With the enable bit low, the signal holds steady red. All configuration goes through a small APB slave with four word registers. One of them is a read-only status word that reports the current phase.

Software first writes the timer words and then sets the enable bit. From then on the phase sequence runs by itself. Changing the profile bit or a timer word alters the timing from the next phase boundary onward.

Top module: `tl_signal_ctrl`

## Requirements
- R1: The register at byte offset 0x4 (timer set 0) and the one at 0x8 (timer set 1) are full 32-bit read/write words. A write is captured when psel, penable and pwrite are all high. Read data appears on prdata while psel and penable are high and pwrite is low.
- R2: The control word at offset 0x0 keeps only bits [3:0]: bit 0 enable, bit 1 yellow flash, bit 2 red flash, bit 3 profile. Higher bits read back as zero.
- R3: After reset the control word reads 0, timer set 0 reads 0xCAFE1234, timer set 1 reads 0xFACE5678 and the status word reads 0.
- R4: The status word at offset 0xC reads the phase code in bits [1:0]: 0 red, 1 green, 2 yellow, 3 dark. Bus writes to it change nothing.
- R5: Reads of any other address return zero, and writes to such addresses are ignored.
- R6: While the enable bit is 0 the phase is red and the controller stays there.
- R7: In normal operation the phases run red, then green, then yellow, then back to red. Green lasts the field in bits [31:20] of the active timer word, red lasts bits [19:8] and yellow lasts bits [7:0], each counted in clocks.
- R8: With the profile bit at 1 the durations come from timer set 1; with it at 0 they come from timer set 0.
- R9: A duration field of zero makes that phase last exactly one clock.
- R10: A new profile bit or timer value is used only from the next phase entry; a countdown already in progress keeps its duration.
- R11: In yellow-flash mode, yellow and dark alternate, each lasting the bits [7:0] duration.
- R12: Red flash overrides yellow flash: with both flash bits set, red and dark alternate and yellow and green stay off.
- R13: Clearing both flash bits while enabled returns the controller to red, and the normal cycle restarts from a full red duration.
- R14: The lamp outputs are one-hot for red, green and yellow. All three are off in the dark phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB direction, 1 = write |
| paddr | input | 32 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data, zero outside a read access |
| lamp_red | output | 1 | Red lamp on |
| lamp_yellow | output | 1 | Yellow lamp on |
| lamp_green | output | 1 | Green lamp on |

## Verification
Some properties are checked by the assertions on every clock:
- the held red while disabled;
- the only legal exits from green and from yellow;
- red taking precedence over yellow flashing;
- the dark phase appearing only under a flash mode;
- the one-hot lamps;
- the timer words holding their value when they are not addressed.

Other behaviour can only be shown by the bench's scenarios, which measure phase lengths at the lamp pins:
- the exact phase lengths under each profile;
- the one-clock treatment of zero fields;
- the deferral of timing changes to the next phase entry;
- the flash periods;
- the register map contents seen over the bus.

// File: rtl/tl_pkg.sv
// Shared types for the traffic light sequencer.
// Assumes a 2-bit phase code that software reads through the status word.
package tl_pkg;
    typedef enum logic [1:0] {
        PH_RED    = 2'b00,
        PH_GREEN  = 2'b01,
        PH_YELLOW = 2'b10,
        PH_DARK   = 2'b11
    } phase_t;
endpackage

// File: rtl/tl_apb_regs.sv
// APB register file: control, two packed timer words, read-only status.
// Assumes zero-wait-state transfers; no error response is produced.
module tl_apb_regs #(
    parameter int          DATA_W = 32,
    parameter int          ADDR_W = 32,
    parameter int          CTRL_W = 4,
    parameter logic [31:0] T0_RST = 32'hCAFE1234,
    parameter logic [31:0] T1_RST = 32'hFACE5678
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    input  tl_pkg::phase_t    phase,
    output logic [CTRL_W-1:0] ctrl,
    output logic [DATA_W-1:0] tmr0,
    output logic [DATA_W-1:0] tmr1
);
    localparam logic [ADDR_W-1:0] OFS_CTRL = ADDR_W'(32'h0);
    localparam logic [ADDR_W-1:0] OFS_TMR0 = ADDR_W'(32'h4);
    localparam logic [ADDR_W-1:0] OFS_TMR1 = ADDR_W'(32'h8);
    localparam logic [ADDR_W-1:0] OFS_STAT = ADDR_W'(32'hC);

    logic wr_en, rd_en;
    logic [DATA_W-1:0] rd_mux;

    assign wr_en = psel && penable && pwrite;
    assign rd_en = psel && penable && !pwrite;

    // Capture bus writes into the writable registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
            tmr0 <= DATA_W'(T0_RST);
            tmr1 <= DATA_W'(T1_RST);
        end else if (wr_en) begin
            if (paddr == OFS_CTRL) ctrl <= pwdata[CTRL_W-1:0];
            if (paddr == OFS_TMR0) tmr0 <= pwdata;
            if (paddr == OFS_TMR1) tmr1 <= pwdata;
        end
    end

    // Select read data by address; unmapped offsets read as zero.
    always_comb begin
        rd_mux = '0;
        if (paddr == OFS_CTRL) rd_mux = DATA_W'(ctrl);
        if (paddr == OFS_TMR0) rd_mux = tmr0;
        if (paddr == OFS_TMR1) rd_mux = tmr1;
        if (paddr == OFS_STAT) rd_mux = DATA_W'(phase);
    end

    // Drive prdata only during a read access.
    assign prdata = rd_en ? rd_mux : '0;

    // R1: a timer word changes only under a write to its own offset.
    a_r1_tmr0_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && paddr == OFS_TMR0) |=> $stable(tmr0));
    a_r1_tmr1_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && paddr == OFS_TMR1) |=> $stable(tmr1));
endmodule

// File: rtl/tl_dur_clamp.sv
// Turns a duration field into a countdown load value (duration - 1).
// A zero field is clamped to a one-clock phase so the sequence never stalls.
module tl_dur_clamp #(
    parameter int W     = 8,
    parameter int OUT_W = 12
) (
    input  logic [W-1:0]     fld,
    output logic [OUT_W-1:0] ld
);
    // Zero and one both give a load of zero, i.e. one clock.
    assign ld = (fld == '0) ? '0 : OUT_W'(fld - W'(1));
endmodule

// File: rtl/tl_phase_fsm.sv
// Phase state machine with down-counter and flash overrides.
// Assumes load values are (duration - 1), sampled at each phase entry only.
module tl_phase_fsm #(
    parameter int CNT_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic               flash_y,
    input  logic               flash_r,
    input  logic [CNT_W-1:0]   ld_g2y,
    input  logic [CNT_W-1:0]   ld_r2g,
    input  logic [CNT_W-1:0]   ld_y2r,
    output tl_pkg::phase_t     phase
);
    import tl_pkg::*;

    logic [CNT_W-1:0] cnt;
    logic             flashing;
    logic             flash_any;
    phase_t           flash_lamp;

    assign flash_any  = flash_r || flash_y;
    assign flash_lamp = flash_r ? PH_RED : PH_YELLOW;

    // Advance phase, countdown and flash flag once per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_RED;
            cnt      <= '0;
            flashing <= 1'b0;
        end else if (!en) begin
            phase    <= PH_RED;
            cnt      <= ld_r2g;
            flashing <= 1'b0;
        end else if (flash_any) begin
            if (!flashing || (phase != PH_DARK && phase != flash_lamp)) begin
                phase    <= flash_lamp;
                cnt      <= ld_y2r;
                flashing <= 1'b1;
            end else if (cnt == '0) begin
                phase <= (phase == PH_DARK) ? flash_lamp : PH_DARK;
                cnt   <= ld_y2r;
            end else begin
                cnt <= cnt - CNT_W'(1);
            end
        end else if (flashing) begin
            phase    <= PH_RED;
            cnt      <= ld_r2g;
            flashing <= 1'b0;
        end else if (cnt == '0) begin
            unique case (phase)
                PH_RED:    begin phase <= PH_GREEN;  cnt <= ld_g2y; end
                PH_GREEN:  begin phase <= PH_YELLOW; cnt <= ld_y2r; end
                PH_YELLOW: begin phase <= PH_RED;    cnt <= ld_r2g; end
                default:   begin phase <= PH_RED;    cnt <= ld_r2g; end
            endcase
        end else begin
            cnt <= cnt - CNT_W'(1);
        end
    end

    // R6: disabled means red on the next clock.
    a_r6_disabled_red: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> phase == PH_RED);
    // R7: green may only stay or move to yellow in normal operation.
    a_r7_green_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !flash_any && phase == PH_GREEN) |=> (phase == PH_GREEN || phase == PH_YELLOW));
    // R7: yellow may only stay or move to red in normal operation.
    a_r7_yellow_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !flash_any && phase == PH_YELLOW) |=> (phase == PH_YELLOW || phase == PH_RED));
    // R12: red flash request excludes yellow and green.
    a_r12_red_priority: assert property (@(posedge clk) disable iff (!rst_n)
        (en && flash_r) |=> (phase == PH_RED || phase == PH_DARK));
    // R11: the dark phase follows only a cycle with a flash mode active.
    a_r11_dark_only_flash: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_DARK) |-> $past(en && flash_any));
endmodule

// File: rtl/tl_signal_ctrl.sv
// Top: APB-configured traffic light sequencer with one-hot lamp outputs.
// Assumes timer words pack G2Y above R2G above Y2R, filling DATA_W exactly.
module tl_signal_ctrl #(
    parameter int          DATA_W = 32,
    parameter int          ADDR_W = 32,
    parameter int          G2Y_W  = 12,
    parameter int          R2G_W  = 12,
    parameter int          Y2R_W  = 8,
    parameter logic [31:0] T0_RST = 32'hCAFE1234,
    parameter logic [31:0] T1_RST = 32'hFACE5678
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    output logic              lamp_red,
    output logic              lamp_yellow,
    output logic              lamp_green
);
    import tl_pkg::*;

    localparam int CTRL_W  = 4;
    localparam int Y2R_LSB = 0;
    localparam int R2G_LSB = Y2R_LSB + Y2R_W;
    localparam int G2Y_LSB = R2G_LSB + R2G_W;
    localparam int CNT_A   = (G2Y_W > R2G_W) ? G2Y_W : R2G_W;
    localparam int CNT_W   = (CNT_A > Y2R_W) ? CNT_A : Y2R_W;

    logic [CTRL_W-1:0] ctrl;
    logic [DATA_W-1:0] tmr0, tmr1, tmr_act;
    logic [CNT_W-1:0]  ld_g2y, ld_r2g, ld_y2r;
    phase_t            phase;

    tl_apb_regs #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CTRL_W(CTRL_W),
        .T0_RST(T0_RST), .T1_RST(T1_RST)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .phase(phase), .ctrl(ctrl), .tmr0(tmr0), .tmr1(tmr1)
    );

    // Profile bit picks the peak (set 1) or off-peak (set 0) timer word.
    assign tmr_act = ctrl[3] ? tmr1 : tmr0;

    tl_dur_clamp #(.W(G2Y_W), .OUT_W(CNT_W)) u_cl_g2y (
        .fld(tmr_act[G2Y_LSB +: G2Y_W]), .ld(ld_g2y));
    tl_dur_clamp #(.W(R2G_W), .OUT_W(CNT_W)) u_cl_r2g (
        .fld(tmr_act[R2G_LSB +: R2G_W]), .ld(ld_r2g));
    tl_dur_clamp #(.W(Y2R_W), .OUT_W(CNT_W)) u_cl_y2r (
        .fld(tmr_act[Y2R_LSB +: Y2R_W]), .ld(ld_y2r));

    tl_phase_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .en(ctrl[0]), .flash_y(ctrl[1]), .flash_r(ctrl[2]),
        .ld_g2y(ld_g2y), .ld_r2g(ld_r2g), .ld_y2r(ld_y2r),
        .phase(phase)
    );

    // Decode the phase into lamp drives; dark lights nothing.
    assign lamp_red    = (phase == PH_RED);
    assign lamp_yellow = (phase == PH_YELLOW);
    assign lamp_green  = (phase == PH_GREEN);

    // R14: never more than one lamp lit.
    a_r14_lamp_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({lamp_red, lamp_yellow, lamp_green}));
endmodule

// File: tb/tb_tl_signal_ctrl.sv
// Self-checking bench: register vector table, then directed timing scenarios.
module tb_tl_signal_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [31:0] paddr = '0, pwdata = '0;
    logic [31:0] prdata;
    logic        lamp_red, lamp_yellow, lamp_green;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    localparam int S_RED = 0, S_GREEN = 1, S_YELLOW = 2, S_DARK = 3;

    // {address, write data, expected read-back}
    localparam int NV = 7;
    localparam logic [95:0] VEC [NV] = '{
        {32'h0,  32'hFFFF_FFF0, 32'h0},
        {32'h4,  32'h1234_5678, 32'h1234_5678},
        {32'h8,  32'h9ABC_DEF0, 32'h9ABC_DEF0},
        {32'hC,  32'hFFFF_FFFF, 32'h0},
        {32'h10, 32'hFFFF_FFFF, 32'h0},
        {32'h0,  32'h0000_0008, 32'h8},
        {32'h0,  32'h0000_0000, 32'h0}
    };
    localparam string VTAG [NV] = '{"R2", "R1", "R1", "R4", "R5", "R2", "R2"};

    tl_signal_ctrl dut (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .lamp_red(lamp_red), .lamp_yellow(lamp_yellow), .lamp_green(lamp_green)
    );

    always #2 clk = ~clk;

    function automatic bit lamp_is(int s);
        case (s)
            S_RED:    return lamp_red && !lamp_yellow && !lamp_green;
            S_GREEN:  return lamp_green && !lamp_red && !lamp_yellow;
            S_YELLOW: return lamp_yellow && !lamp_red && !lamp_green;
            default:  return !lamp_red && !lamp_yellow && !lamp_green;
        endcase
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(logic [31:0] a, logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic bus_read(logic [31:0] a, output logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
        @(negedge clk);
        penable = 1'b1;
        #1 d = prdata;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic wait_for(int s);
        int t = 0;
        while (!lamp_is(s) && t < 2000) begin
            @(negedge clk);
            t++;
        end
    endtask

    // Length in clocks of the next (or current) run of state s.
    task automatic count_run(int s, output int n);
        n = 0;
        wait_for(s);
        while (lamp_is(s) && n < 2000) begin
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        int n;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 reset values; R6/R14 red lamp alone after reset.
        check("R6 lamps after reset", {29'd0, lamp_red, lamp_yellow, lamp_green}, 32'h4);
        bus_read(32'h0, rd); check("R3 ctrl reset", rd, 32'h0);
        bus_read(32'h4, rd); check("R3 tmr0 reset", rd, 32'hCAFE1234);
        bus_read(32'h8, rd); check("R3 tmr1 reset", rd, 32'hFACE5678);
        bus_read(32'hC, rd); check("R3 status reset", rd, 32'h0);

        // Register vector table.
        for (int i = 0; i < NV; i++) begin
            bus_write(VEC[i][95:64], VEC[i][63:32]);
            bus_read(VEC[i][95:64], rd);
            check(VTAG[i], rd, VEC[i][31:0]);
        end
        bus_read(32'h4, rd); check("R5 tmr0 untouched by unmapped write", rd, 32'h1234_5678);

        // R7 normal cycle, off-peak set: g2y=3, r2g=2, y2r=4.
        bus_write(32'h4, 32'h0030_0204);
        bus_write(32'h0, 32'h1);
        count_run(S_GREEN, n);  check("R7 green length", n, 3);
        count_run(S_YELLOW, n); check("R7 yellow length", n, 4);
        count_run(S_RED, n);    check("R7 red length", n, 2);
        count_run(S_GREEN, n);  check("R7 green again", n, 3);
        wait_for(S_GREEN);
        bus_read(32'hC, rd); check("R4 status green", rd, 32'h1);

        // R8/R10 peak set: g2y=5, r2g=1, y2r=2, applied from next entry.
        bus_write(32'h8, 32'h0050_0102);
        bus_write(32'h0, 32'h9);
        count_run(S_GREEN, n);
        count_run(S_YELLOW, n); check("R8 peak yellow length", n, 2);
        count_run(S_RED, n);    check("R8 peak red length", n, 1);
        count_run(S_GREEN, n);  check("R10 peak green length", n, 5);

        // R9 all-zero fields give one-clock phases.
        bus_write(32'h8, 32'h0);
        count_run(S_GREEN, n);
        count_run(S_YELLOW, n); check("R9 zero yellow", n, 1);
        count_run(S_RED, n);    check("R9 zero red", n, 1);
        count_run(S_GREEN, n);  check("R9 zero green", n, 1);

        // R11 yellow flash with y2r=6 on off-peak set.
        bus_write(32'h4, 32'h0030_0206);
        bus_write(32'h0, 32'h3);
        count_run(S_YELLOW, n);
        count_run(S_DARK, n);   check("R11 dark length", n, 6);
        count_run(S_YELLOW, n); check("R11 yellow flash length", n, 6);
        wait_for(S_DARK);
        bus_read(32'hC, rd); check("R4 status dark", rd, 32'h3);
        wait_for(S_YELLOW);
        bus_read(32'hC, rd); check("R4 status yellow", rd, 32'h2);

        // R12 red flash wins when both flash bits set.
        bus_write(32'h0, 32'h7);
        n = 0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (lamp_yellow || lamp_green) n++;
        end
        check("R12 no yellow/green under red flash", n, 0);
        count_run(S_RED, n);
        count_run(S_DARK, n); check("R12 dark length", n, 6);
        count_run(S_RED, n);  check("R12 red flash length", n, 6);

        // R13 clearing flash returns to red for a full r2g, then green.
        wait_for(S_DARK);
        bus_write(32'h0, 32'h1);
        @(negedge clk);
        check("R13 red after flash clear", {31'd0, lamp_is(S_RED)}, 32'h1);
        count_run(S_RED, n);   check("R13 red length", n, 2);
        count_run(S_GREEN, n); check("R13 green length", n, 3);

        // R6 disable holds red.
        bus_write(32'h0, 32'h0);
        @(negedge clk);
        n = 0;
        for (int k = 0; k < 20; k++) begin
            if (!lamp_is(S_RED)) n++;
            @(negedge clk);
        end
        check("R6 red held while disabled", n, 0);
        bus_read(32'hC, rd); check("R4 status red", rd, 32'h0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule